// File: doc/BRIEF.md
# Inter-Port Semaphore Flag Unit

This unit holds eight shared flags that the two ports of a dual-port memory use to claim and hand back shared resources. Each port reaches the flags only when it asserts its semaphore select while its memory select is inactive. A write takes the flag value from data bit 0. Writing 0 asks for the flag, and writing 1 gives back a flag the writer holds. A read returns the flag as seen by the reading port, copied onto all sixteen data lines. The reader sees 0 when it holds the flag and 1 in every other case.

The unit is synchronous. Both ports share one clock, and each port's request is sampled on a clock edge. The read response, a refusal, or an error indication shows on that port's outputs one cycle after the request. If both ports ask for the same free flag in the same cycle, the left port gets it. A port that writes a flag cannot read that same flag in the next cycle; the unit refuses the read to model the recovery time after a write. A port that drives its semaphore select and memory select together with any byte enable has made an illegal request. The unit reports it and changes no state.

Top module: `sem_flag_unit`

## Requirements
- R1: Address bits 2..0 pick one of eight flags. After reset every flag is free, so a read of any flag from either port returns 16'hFFFF.
- R2: A port accesses the flags when sem_sel=1 and ram_sel=0. In that case wr=1 is a write and wr=0 is a read, and the byte enables have no effect. With sem_sel=0 the port does nothing. With sem_sel=1, ram_sel=1 and both byte enables 0, the port also does nothing.
- R3: A read raises rvalid one cycle later. rdata then carries the flag bit on all 16 lines: 0 if the reading port holds the flag, 1 otherwise. rdata is 0 whenever rvalid is 0.
- R4: A write uses only wdata[0]. Writing 0 to a free flag gives the flag to the writer. Writing 1 to a flag the writer holds frees it. Every other write leaves the flag unchanged.
- R5: sem_sel=1 with ram_sel=1 and ub or lb equal to 1 raises err one cycle later. Such a request produces neither a read nor a write.
- R6: If a port reads a flag in the cycle right after it wrote that same flag, refused goes high one cycle later and rvalid stays low. A read of a different flag in that cycle is served normally.
- R7: If both ports write 0 to the same free flag in the same cycle, the left port receives the flag.
- R8: While one port holds a flag, the other port's request for it and its release of it are both ignored.
- R9: A read returns the flag state from before any write made in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst_n | input | 1 | Active-low synchronous reset |
| l_sem_sel | input | 1 | Left port semaphore select, active high |
| l_ram_sel | input | 1 | Left port memory select, active high |
| l_ub | input | 1 | Left port upper byte enable, active high |
| l_lb | input | 1 | Left port lower byte enable, active high |
| l_wr | input | 1 | Left port write strobe (1 write, 0 read) |
| l_addr | input | 3 | Left port flag index |
| l_wdata | input | 16 | Left port write data, only bit 0 used |
| l_rdata | output | 16 | Left port read data |
| l_rvalid | output | 1 | Left port read response valid |
| l_refused | output | 1 | Left port read refused during recovery |
| l_err | output | 1 | Left port illegal request |
| r_sem_sel | input | 1 | Right port semaphore select, active high |
| r_ram_sel | input | 1 | Right port memory select, active high |
| r_ub | input | 1 | Right port upper byte enable, active high |
| r_lb | input | 1 | Right port lower byte enable, active high |
| r_wr | input | 1 | Right port write strobe (1 write, 0 read) |
| r_addr | input | 3 | Right port flag index |
| r_wdata | input | 16 | Right port write data, only bit 0 used |
| r_rdata | output | 16 | Right port read data |
| r_rvalid | output | 1 | Right port read response valid |
| r_refused | output | 1 | Right port read refused during recovery |
| r_err | output | 1 | Right port illegal request |

## Verification
Some rules are checked by assertions on every cycle:
- A flag changes owner only after a write that hits it.
- A held flag never passes straight to the other port.
- The right port never receives a flag in a cycle when the left port asked for it.
- Read data is always all zeros or all ones.
- An error never appears together with a read response.

Other behaviour shows only in the bench's scenarios:
- Which value each port actually reads back.
- The one-cycle refusal after a write.
- The pre-write view when a read and a write meet in the same cycle.
- The fact that requests with the selects off, and the upper bits of write data, have no effect.

// File: rtl/sem_pkg.sv
package sem_pkg;

  typedef enum logic [1:0] {
    OWN_FREE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2,
    OWN_RSVD  = 2'd3
  } owner_e;

  // Owner code that stands for a given port.
  function automatic owner_e port_code(input logic is_right);
    return is_right ? OWN_RIGHT : OWN_LEFT;
  endfunction

  // Flag bit as one port sees it: 0 only when that port holds the flag.
  function automatic logic seen_bit(input owner_e own, input logic is_right);
    return (own != port_code(is_right));
  endfunction

endpackage

// File: rtl/sem_port_decode.sv
module sem_port_decode #(
  parameter int IDX_W  = 3,
  parameter int DATA_W = 16
) (
  input  logic              sem_sel,
  input  logic              ram_sel,
  input  logic              ub,
  input  logic              lb,
  input  logic              wr,
  input  logic [IDX_W-1:0]  addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              rd_req,
  output logic              wr_req,
  output logic              wr_val,
  output logic              err_req,
  output logic [IDX_W-1:0]  idx
);

  logic sem_access;
  logic unused_wdata_hi;

  assign sem_access = sem_sel && !ram_sel;
  assign err_req    = sem_sel && ram_sel && (ub || lb);
  assign rd_req     = sem_access && !wr;
  assign wr_req     = sem_access && wr;
  assign wr_val     = wdata[0];
  assign idx        = addr;
  assign unused_wdata_hi = ^wdata[DATA_W-1:1];

endmodule

// File: rtl/sem_flag_bank.sv
module sem_flag_bank
  import sem_pkg::*;
#(
  parameter int NUM_FLAGS = 8,
  parameter int IDX_W     = 3
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [1:0]                  wr_req,
  input  logic [1:0]                  wr_val,
  input  logic [IDX_W-1:0]            idx_l,
  input  logic [IDX_W-1:0]            idx_r,
  output logic [NUM_FLAGS-1:0][1:0]   owner_vec
);

  owner_e owner_q [NUM_FLAGS];

  // Named per-flag events, brought out for the assertions.
  logic [NUM_FLAGS-1:0] hit_l, hit_r;
  logic [NUM_FLAGS-1:0] ask_l, ask_r;
  logic [NUM_FLAGS-1:0] take_l, take_r;
  logic [NUM_FLAGS-1:0] give_l, give_r;

  for (genvar f = 0; f < NUM_FLAGS; f++) begin : g_flag
    assign hit_l[f]  = wr_req[0] && (idx_l == IDX_W'(f));
    assign hit_r[f]  = wr_req[1] && (idx_r == IDX_W'(f));
    assign ask_l[f]  = hit_l[f] && !wr_val[0];
    assign ask_r[f]  = hit_r[f] && !wr_val[1];
    // Left side wins a same-cycle request for a free flag.
    assign take_l[f] = ask_l[f] && (owner_q[f] == OWN_FREE);
    assign take_r[f] = ask_r[f] && (owner_q[f] == OWN_FREE) && !ask_l[f];
    assign give_l[f] = hit_l[f] && wr_val[0] && (owner_q[f] == OWN_LEFT);
    assign give_r[f] = hit_r[f] && wr_val[1] && (owner_q[f] == OWN_RIGHT);

    always_ff @(posedge clk) begin
      if (!rst_n)                    owner_q[f] <= OWN_FREE;
      else if (take_l[f])            owner_q[f] <= OWN_LEFT;
      else if (take_r[f])            owner_q[f] <= OWN_RIGHT;
      else if (give_l[f] || give_r[f]) owner_q[f] <= OWN_FREE;
    end

    assign owner_vec[f] = owner_q[f];

    AST_CHANGE_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (owner_q[f] != $past(owner_q[f])) |-> $past(hit_l[f] || hit_r[f])); // R4
    AST_NO_STEAL: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(owner_q[f]) != OWN_FREE) |-> (owner_q[f] == $past(owner_q[f]) || owner_q[f] == OWN_FREE)); // R8
    AST_LEFT_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(owner_q[f]) == OWN_FREE && owner_q[f] == OWN_RIGHT) |-> !$past(ask_l[f])); // R7
  end

endmodule

// File: rtl/sem_port_resp.sv
module sem_port_resp
  import sem_pkg::*;
#(
  parameter int   IDX_W    = 3,
  parameter int   DATA_W   = 16,
  parameter logic IS_RIGHT = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_req,
  input  logic              wr_req,
  input  logic              err_req,
  input  logic [IDX_W-1:0]  idx,
  input  owner_e            cur_owner,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid,
  output logic              refused,
  output logic              err
);

  logic             last_wr_q;
  logic [IDX_W-1:0] last_idx_q;
  logic             in_recovery;
  logic             serve_rd;

  // Recovery window: same flag written by this port on the previous cycle.
  function automatic logic blocks_read(input logic lw, input logic [IDX_W-1:0] li,
                                       input logic [IDX_W-1:0] ri);
    return lw && (li == ri);
  endfunction

  assign in_recovery = rd_req && blocks_read(last_wr_q, last_idx_q, idx);
  assign serve_rd    = rd_req && !in_recovery;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_wr_q  <= 1'b0;
      last_idx_q <= '0;
      rvalid     <= 1'b0;
      refused    <= 1'b0;
      err        <= 1'b0;
      rdata      <= '0;
    end else begin
      last_wr_q  <= wr_req;
      last_idx_q <= idx;
      rvalid     <= serve_rd;
      refused    <= in_recovery;
      err        <= err_req;
      rdata      <= serve_rd ? {DATA_W{seen_bit(cur_owner, IS_RIGHT)}} : '0;
    end
  end

  AST_REPLICATED_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |-> (rdata == '0 || rdata == '1)); // R3
  AST_QUIET_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    !rvalid |-> (rdata == '0)); // R3
  AST_ERR_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!rvalid && !refused)); // R5

endmodule

// File: rtl/sem_flag_unit.sv
module sem_flag_unit
  import sem_pkg::*;
#(
  parameter int NUM_FLAGS = 8,
  parameter int DATA_W    = 16,
  parameter int IDX_W     = $clog2(NUM_FLAGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l_sem_sel,
  input  logic              l_ram_sel,
  input  logic              l_ub,
  input  logic              l_lb,
  input  logic              l_wr,
  input  logic [IDX_W-1:0]  l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata,
  output logic              l_rvalid,
  output logic              l_refused,
  output logic              l_err,
  input  logic              r_sem_sel,
  input  logic              r_ram_sel,
  input  logic              r_ub,
  input  logic              r_lb,
  input  logic              r_wr,
  input  logic [IDX_W-1:0]  r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata,
  output logic              r_rvalid,
  output logic              r_refused,
  output logic              r_err
);

  localparam int NPORT = 2;

  logic [NPORT-1:0]              sem_sel_a, ram_sel_a, ub_a, lb_a, wr_a;
  logic [NPORT-1:0][IDX_W-1:0]   addr_a, idx_a;
  logic [NPORT-1:0][DATA_W-1:0]  wdata_a, rdata_a;
  logic [NPORT-1:0]              rd_req_a, wr_req_a, wr_val_a, err_req_a;
  logic [NPORT-1:0]              rvalid_a, refused_a, err_a;
  logic [NUM_FLAGS-1:0][1:0]     owner_vec;

  assign sem_sel_a = {r_sem_sel, l_sem_sel};
  assign ram_sel_a = {r_ram_sel, l_ram_sel};
  assign ub_a      = {r_ub, l_ub};
  assign lb_a      = {r_lb, l_lb};
  assign wr_a      = {r_wr, l_wr};
  assign addr_a    = {r_addr, l_addr};
  assign wdata_a   = {r_wdata, l_wdata};

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    sem_port_decode #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_dec (
      .sem_sel (sem_sel_a[p]),
      .ram_sel (ram_sel_a[p]),
      .ub      (ub_a[p]),
      .lb      (lb_a[p]),
      .wr      (wr_a[p]),
      .addr    (addr_a[p]),
      .wdata   (wdata_a[p]),
      .rd_req  (rd_req_a[p]),
      .wr_req  (wr_req_a[p]),
      .wr_val  (wr_val_a[p]),
      .err_req (err_req_a[p]),
      .idx     (idx_a[p])
    );

    sem_port_resp #(.IDX_W(IDX_W), .DATA_W(DATA_W), .IS_RIGHT(p == 1)) u_resp (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_req    (rd_req_a[p]),
      .wr_req    (wr_req_a[p]),
      .err_req   (err_req_a[p]),
      .idx       (idx_a[p]),
      .cur_owner (owner_e'(owner_vec[idx_a[p]])),
      .rdata     (rdata_a[p]),
      .rvalid    (rvalid_a[p]),
      .refused   (refused_a[p]),
      .err       (err_a[p])
    );
  end

  sem_flag_bank #(.NUM_FLAGS(NUM_FLAGS), .IDX_W(IDX_W)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_req    (wr_req_a),
    .wr_val    (wr_val_a),
    .idx_l     (idx_a[0]),
    .idx_r     (idx_a[1]),
    .owner_vec (owner_vec)
  );

  assign l_rdata   = rdata_a[0];
  assign l_rvalid  = rvalid_a[0];
  assign l_refused = refused_a[0];
  assign l_err     = err_a[0];
  assign r_rdata   = rdata_a[1];
  assign r_rvalid  = rvalid_a[1];
  assign r_refused = refused_a[1];
  assign r_err     = err_a[1];

endmodule

// File: tb/sem_flag_unit_tb.sv
module sem_flag_unit_tb;

  localparam int K_IDLE = 0, K_RD = 1, K_WR = 2, K_ERR = 3, K_OFF = 4, K_BOTH_NOBYTE = 5;

  typedef struct {
    logic        rvalid;
    logic        refused;
    logic        err;
    logic [15:0] rdata;
    string       tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic l_sem_sel, l_ram_sel, l_ub, l_lb, l_wr;
  logic [2:0] l_addr;
  logic [15:0] l_wdata, l_rdata;
  logic l_rvalid, l_refused, l_err;
  logic r_sem_sel, r_ram_sel, r_ub, r_lb, r_wr;
  logic [2:0] r_addr;
  logic [15:0] r_wdata, r_rdata;
  logic r_rvalid, r_refused, r_err;

  sem_flag_unit u_dut (
    .clk(clk), .rst_n(rst_n),
    .l_sem_sel(l_sem_sel), .l_ram_sel(l_ram_sel), .l_ub(l_ub), .l_lb(l_lb), .l_wr(l_wr),
    .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata), .l_rvalid(l_rvalid),
    .l_refused(l_refused), .l_err(l_err),
    .r_sem_sel(r_sem_sel), .r_ram_sel(r_ram_sel), .r_ub(r_ub), .r_lb(r_lb), .r_wr(r_wr),
    .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata), .r_rvalid(r_rvalid),
    .r_refused(r_refused), .r_err(r_err)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  exp_t q_l[$];
  exp_t q_r[$];

  // Bench model: 0 free, 1 left holds, 2 right holds.
  int own [8];
  bit last_w [2];
  int last_i [2];

  task automatic compare(input string side, input exp_t e, input logic v, input logic rf,
                         input logic er, input logic [15:0] d);
    checks++;
    if (v !== e.rvalid || rf !== e.refused || er !== e.err || d !== e.rdata) begin
      fails++;
      $display("FAIL %s %s: got v=%0b ref=%0b err=%0b data=%h, expected v=%0b ref=%0b err=%0b data=%h",
               e.tag, side, v, rf, er, d, e.rvalid, e.refused, e.err, e.rdata);
    end
  endtask

  // Monitor: outputs settle at the posedge; compare shortly after it.
  always @(posedge clk) begin
    #1;
    if (q_l.size() > 0) compare("left", q_l.pop_front(), l_rvalid, l_refused, l_err, l_rdata);
    if (q_r.size() > 0) compare("right", q_r.pop_front(), r_rvalid, r_refused, r_err, r_rdata);
  end

  function automatic exp_t predict(input int p, input int k, input int i, input string tag);
    exp_t e;
    e.rvalid = 0; e.refused = 0; e.err = 0; e.rdata = 16'h0000; e.tag = tag;
    if (k == K_RD) begin
      if (last_w[p] && last_i[p] == i) e.refused = 1;
      else begin
        e.rvalid = 1;
        e.rdata  = (own[i] == p + 1) ? 16'h0000 : 16'hFFFF;
      end
    end else if (k == K_ERR) e.err = 1;
    return e;
  endfunction

  task automatic cyc(input int lk, input int li, input int lv,
                     input int rk, input int ri, input int rv, input string tag);
    int pre_l, pre_r;
    @(negedge clk);
    // Left pins
    l_sem_sel = (lk == K_RD || lk == K_WR || lk == K_ERR || lk == K_BOTH_NOBYTE);
    l_ram_sel = (lk == K_ERR || lk == K_BOTH_NOBYTE);
    l_ub = (lk == K_ERR) ? 1'b1 : (lk == K_RD || lk == K_WR);
    l_lb = (lk == K_RD);
    l_wr = (lk == K_WR || lk == K_ERR || lk == K_OFF || lk == K_BOTH_NOBYTE);
    l_addr = 3'(li);
    l_wdata = lv[0] ? 16'h5A5B : 16'hA5A4;
    // Right pins
    r_sem_sel = (rk == K_RD || rk == K_WR || rk == K_ERR || rk == K_BOTH_NOBYTE);
    r_ram_sel = (rk == K_ERR || rk == K_BOTH_NOBYTE);
    r_ub = (rk == K_RD);
    r_lb = (rk == K_ERR) ? 1'b1 : (rk == K_WR);
    r_wr = (rk == K_WR || rk == K_ERR || rk == K_OFF || rk == K_BOTH_NOBYTE);
    r_addr = 3'(ri);
    r_wdata = rv[0] ? 16'hFFFF : 16'hFFFE;
    q_l.push_back(predict(0, lk, li, tag));
    q_r.push_back(predict(1, rk, ri, tag));
    // State update from pre-cycle state.
    pre_l = own[li];
    pre_r = own[ri];
    if (lk == K_WR) begin
      if (lv == 0 && pre_l == 0) own[li] = 1;
      else if (lv == 1 && pre_l == 1) own[li] = 0;
    end
    if (rk == K_WR) begin
      if (rv == 0 && pre_r == 0 && !(lk == K_WR && lv == 0 && li == ri)) own[ri] = 2;
      else if (rv == 1 && pre_r == 2) own[ri] = 0;
    end
    last_w[0] = (lk == K_WR); last_i[0] = li;
    last_w[1] = (rk == K_WR); last_i[1] = ri;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got no completion, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int f = 0; f < 8; f++) own[f] = 0;
    for (int p = 0; p < 2; p++) begin last_w[p] = 0; last_i[p] = 0; end
    l_sem_sel = 0; l_ram_sel = 0; l_ub = 0; l_lb = 0; l_wr = 0; l_addr = 0; l_wdata = 0;
    r_sem_sel = 0; r_ram_sel = 0; r_ub = 0; r_lb = 0; r_wr = 0; r_addr = 0; r_wdata = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    cyc(K_IDLE, 0, 0, K_IDLE, 0, 0, "R1_reset_idle");
    for (int f = 0; f < 8; f++) cyc(K_RD, f, 0, K_RD, 7 - f, 0, "R1_all_free");

    // Request, recovery, hold
    cyc(K_WR, 3, 0, K_IDLE, 0, 0, "R4_request");
    cyc(K_RD, 3, 0, K_RD, 3, 0, "R6_refuse_same_flag");
    cyc(K_RD, 3, 0, K_RD, 3, 0, "R3_holder_view");
    cyc(K_WR, 4, 1, K_WR, 3, 0, "R8_steal_attempt");
    cyc(K_RD, 5, 0, K_WR, 3, 1, "R6_other_flag_ok");
    cyc(K_RD, 3, 0, K_IDLE, 0, 0, "R8_still_left");
    cyc(K_IDLE, 0, 0, K_RD, 3, 0, "R8_right_view");

    // Same-cycle contention
    cyc(K_WR, 5, 0, K_WR, 5, 0, "R7_tie");
    cyc(K_IDLE, 0, 0, K_IDLE, 0, 0, "R7_gap");
    cyc(K_RD, 5, 0, K_RD, 5, 0, "R7_left_wins");

    // Data bit 0 only
    cyc(K_IDLE, 0, 0, K_WR, 6, 0, "R4_bit0_zero");
    cyc(K_WR, 6, 0, K_WR, 1, 1, "R4_release_not_held");
    cyc(K_IDLE, 0, 0, K_RD, 6, 0, "R4_right_holds");
    cyc(K_RD, 6, 0, K_RD, 1, 0, "R4_left_view");

    // Illegal and inactive requests
    cyc(K_ERR, 0, 0, K_ERR, 2, 0, "R5_illegal");
    cyc(K_RD, 0, 0, K_RD, 2, 0, "R5_no_change");
    cyc(K_OFF, 1, 0, K_BOTH_NOBYTE, 7, 0, "R2_inactive");
    cyc(K_RD, 1, 0, K_RD, 7, 0, "R2_no_effect");
    cyc(K_RD, 7, 0, K_RD, 1, 0, "R2_no_effect_cross");

    // Read sees pre-write state
    cyc(K_RD, 2, 0, K_WR, 2, 0, "R9_pre_write");
    cyc(K_RD, 2, 0, K_RD, 2, 0, "R9_after");
    cyc(K_IDLE, 0, 0, K_RD, 2, 0, "R9_right_holds");

    // Release and hand over
    cyc(K_WR, 3, 1, K_IDLE, 0, 0, "R4_release");
    cyc(K_IDLE, 0, 0, K_WR, 3, 0, "R4_handover");
    cyc(K_RD, 3, 0, K_IDLE, 0, 0, "R4_left_after_release");
    cyc(K_IDLE, 0, 0, K_RD, 3, 0, "R4_right_owns");
    cyc(K_WR, 5, 1, K_WR, 5, 0, "R8_release_vs_request");
    cyc(K_RD, 6, 0, K_RD, 4, 0, "R8_gap");
    cyc(K_RD, 5, 0, K_RD, 5, 0, "R8_free_after");
    cyc(K_IDLE, 0, 0, K_IDLE, 0, 0, "R3_idle_zero");

    repeat (3) @(posedge clk);
    #2;
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule